// File: doc/BRIEF.md
# 256-byte NAND Hamming ECC generator

This block sits beside the byte path between a NAND flash and memory. It computes single-error-correcting Hamming parity over the bytes flowing through it, one result per 256-byte chunk. Bytes are taken in when both the enable and the byte-valid input are high. After the last byte of a chunk, the chunk's parity is latched into an output register and a one-cycle pulse is raised. The accumulator then starts the next chunk on its own.

A clear input drops any partial chunk, for example before a new page transfer begins. The raw parity word carries the column parity in its low six bits and the line parity above them. A formatter turns the latched word into the three bytes that software stores in the flash spare area. The result of the last chunk of a page comes out one cycle after that chunk's final byte. The host therefore reads it once the data stream has ended.

Top module: `hamming256_ecc_gen`

## Requirements
- R1: After reset, `parity_valid_o` is 0, `parity_o` is 0 and `spare_o` is 24'hFFFFFF.
- R2: Column parity sits in `parity_o[5:0]`. For each bit j of a bit position p (0..7) inside a byte, bit 2j is the XOR of all chunk data bits with p[j]=0, and bit 2j+1 is the XOR of those with p[j]=1.
- R3: Line parity sits in `parity_o[21:6]`. For each bit k of a byte's address a (0..255) within its chunk, `parity_o[6+2k]` is the XOR of the byte parities of all bytes with a[k]=0, and `parity_o[7+2k]` is the XOR of those with a[k]=1.
- R4: A byte is taken in only on a clock edge where `enable_i` and `byte_valid_i` are both 1. On any other edge the accumulated parity and the byte count are left unchanged.
- R5: The cycle after the edge that takes in the 256th byte of a chunk, `parity_valid_o` is 1 for exactly one cycle. In that same cycle `parity_o` holds the parity of that chunk, and no pulse occurs earlier.
- R6: After a chunk completes, the next accepted byte is address 0 of a fresh chunk whose parity starts from zero, with no idle cycle required.
- R7: On an edge where `clear_i` is 1, the partial chunk's parity and count are discarded, even if a byte is offered on that same edge (that byte is dropped). `parity_o` is not changed.
- R8: `parity_o` and `spare_o` change only when a new chunk result is latched.
- R9: The stored form s is the low 24 bits of the bitwise inverse of `parity_o` shifted left by two, so s[1:0] is always 2'b11.
- R10: Spare byte offset n appears on `spare_o[8n+7:8n]`. Offset 0 carries s[23:16], offset 1 carries s[15:8] and offset 2 carries s[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Discard the partial chunk |
| enable_i | input | 1 | Parity accumulation enable |
| byte_valid_i | input | 1 | Data byte present this cycle |
| byte_i | input | 8 | Data byte |
| parity_valid_o | output | 1 | One-cycle pulse when a chunk result is latched |
| parity_o | output | 22 | Latched raw parity: column bits [5:0], line bits [21:6] |
| spare_o | output | 24 | Stored spare bytes, offset n at bits [8n+7:8n] |

## Verification
The assertions check every cycle that:
- ignored or cleared edges leave the accumulator untouched;
- the done pulse lasts one cycle and follows the final byte of a chunk;
- the latched result holds between pulses;
- the two forced-one bits of the stored form are in place.

Only the bench's scenarios can show that the parity equations themselves are right and that the spare bytes come out in the right order. For that, the bench compares each chunk against a bit-by-bit model. The chunks include zero data, random data, data with gaps and junk on disabled cycles, a single set bit, back-to-back chunks, and a clear in the middle of a chunk or on the same edge as a byte.

// File: rtl/ecc256_pkg.sv
package ecc256_pkg;
    localparam int BYTE_W    = 8;
    localparam int BITSEL_W  = $clog2(BYTE_W);
    localparam int COL_W     = 2 * BITSEL_W;
    localparam int PAD_W     = 2;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ecc_col_parity.sv
module ecc_col_parity
    import ecc256_pkg::*;
(
    input  byte_t             data_i,
    output logic [COL_W-1:0]  col_o,
    output logic              byte_par_o
);
    always_comb begin
        col_o = '0;
        for (int j = 0; j < BITSEL_W; j++) begin
            for (int p = 0; p < BYTE_W; p++) begin
                if (p[j]) col_o[2*j+1] = col_o[2*j+1] ^ data_i[p];
                else      col_o[2*j]   = col_o[2*j]   ^ data_i[p];
            end
        end
        byte_par_o = ^data_i;
    end
endmodule

// File: rtl/ecc_line_mask.sv
module ecc_line_mask #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                par_i,
    output logic [2*ADDR_W-1:0] mask_o
);
    for (genvar k = 0; k < ADDR_W; k++) begin : g_pair
        assign mask_o[2*k]   = par_i & ~addr_i[k];
        assign mask_o[2*k+1] = par_i &  addr_i[k];
    end
endmodule

// File: rtl/ecc_spare_fmt.sv
module ecc_spare_fmt
    import ecc256_pkg::*;
#(
    parameter int RAW_W   = 22,
    parameter int SPARE_N = 3
) (
    input  logic [RAW_W-1:0]          raw_i,
    output logic [SPARE_N*BYTE_W-1:0] spare_o
);
    localparam int STORE_W = SPARE_N * BYTE_W;
    localparam int EXT_W   = STORE_W - RAW_W - PAD_W;

    logic [STORE_W-1:0] stored;

    if (EXT_W > 0) begin : g_ext
        assign stored = ~{{EXT_W{1'b0}}, raw_i, {PAD_W{1'b0}}};
    end else begin : g_exact
        assign stored = ~{raw_i, {PAD_W{1'b0}}};
    end

    for (genvar n = 0; n < SPARE_N; n++) begin : g_byte
        assign spare_o[n*BYTE_W +: BYTE_W] = stored[(SPARE_N-1-n)*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/hamming256_ecc_gen.sv
module hamming256_ecc_gen
    import ecc256_pkg::*;
#(
    parameter int CHUNK_BYTES = 256,
    parameter int SPARE_N     = 3
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         clear_i,
    input  logic                                         enable_i,
    input  logic                                         byte_valid_i,
    input  logic [7:0]                                   byte_i,
    output logic                                         parity_valid_o,
    output logic [COL_W+2*$clog2(CHUNK_BYTES)-1:0]      parity_o,
    output logic [SPARE_N*8-1:0]                         spare_o
);
    localparam int ADDR_W = $clog2(CHUNK_BYTES);
    localparam int LINE_W = 2 * ADDR_W;
    localparam int RAW_W  = COL_W + LINE_W;
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(CHUNK_BYTES - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] cnt;
        logic [RAW_W-1:0]  acc;
        logic [RAW_W-1:0]  result;
        logic              valid;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic [COL_W-1:0]  col_bits;
    logic              byte_par;
    logic [LINE_W-1:0] line_bits;
    logic              accept;
    logic [RAW_W-1:0]  acc_next;

    ecc_col_parity u_col (
        .data_i     (byte_i),
        .col_o      (col_bits),
        .byte_par_o (byte_par)
    );

    ecc_line_mask #(.ADDR_W(ADDR_W)) u_line (
        .addr_i (st_q.cnt),
        .par_i  (byte_par),
        .mask_o (line_bits)
    );

    ecc_spare_fmt #(.RAW_W(RAW_W), .SPARE_N(SPARE_N)) u_fmt (
        .raw_i   (st_q.result),
        .spare_o (spare_o)
    );

    always_comb begin
        accept   = enable_i & byte_valid_i;
        acc_next = st_q.acc ^ {line_bits, col_bits};
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (clear_i) begin
            st_d.cnt = '0;
            st_d.acc = '0;
        end else if (accept) begin
            if (st_q.cnt == LAST_IDX) begin
                st_d.result = acc_next;
                st_d.valid  = 1'b1;
                st_d.cnt    = '0;
                st_d.acc    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                st_d.acc = acc_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign parity_valid_o = st_q.valid;
    assign parity_o       = st_q.result;

    // R4: edges that take in no byte leave the accumulation untouched
    p_idle_keeps_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !(enable_i && byte_valid_i)) |=> ($stable(st_q.acc) && $stable(st_q.cnt)));

    // R5, R6: the last byte gives a pulse and a fresh accumulator
    p_last_byte_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && enable_i && byte_valid_i && st_q.cnt == LAST_IDX)
        |=> (parity_valid_o && st_q.cnt == '0 && st_q.acc == '0));

    // R5: the done pulse lasts one cycle
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        parity_valid_o |=> !parity_valid_o);

    // R7: clear discards the partial chunk but keeps the latched result
    p_clear_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.cnt == '0 && st_q.acc == '0 && $stable(parity_o)));

    // R8: the result holds unless a chunk completes
    p_result_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!clear_i && enable_i && byte_valid_i && st_q.cnt == LAST_IDX) |=> $stable(parity_o));

    // R9: the two shifted-in bits land inverted in the last stored byte
    p_pad_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        spare_o[(SPARE_N-1)*8 +: 2] == 2'b11);
endmodule

// File: tb/hamming256_ecc_gen_tb.sv
module hamming256_ecc_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic        enable_i = 1'b0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic        parity_valid_o;
    logic [21:0] parity_o;
    logic [23:0] spare_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    logic [7:0] mem [256];

    always #10 clk = ~clk;

    hamming256_ecc_gen u_dut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .enable_i(enable_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i),
        .parity_valid_o(parity_valid_o), .parity_o(parity_o), .spare_o(spare_o)
    );

    function automatic logic [21:0] model_raw();
        logic [15:0] line = '0;
        logic [5:0]  col  = '0;
        for (int a = 0; a < 256; a++) begin
            for (int p = 0; p < 8; p++) begin
                if (mem[a][p]) begin
                    for (int k = 0; k < 8; k++) line[2*k + int'(a[k])] ^= 1'b1;
                    for (int j = 0; j < 3; j++) col[2*j + int'(p[j])] ^= 1'b1;
                end
            end
        end
        return {line, col};
    endfunction

    function automatic logic [23:0] model_spare(input logic [21:0] raw);
        logic [23:0] s = ~{raw, 2'b00};
        return {s[7:0], s[15:8], s[23:16]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic en, input logic v, input logic clr, input logic [7:0] b);
        enable_i = en; byte_valid_i = v; clear_i = clr; byte_i = b;
        @(negedge clk);
    endtask

    task automatic idle_junk();
        logic sel = 1'($urandom);
        drive(sel, ~sel, 1'b0, 8'($urandom));
    endtask

    task automatic run_chunk(input string req, input bit gaps);
        logic [21:0] exp_raw = model_raw();
        bit early = 1'b0;
        for (int i = 0; i < 256; i++) begin
            if (gaps && ($urandom % 3 == 0)) begin
                for (int g = 0; g < 1 + int'($urandom % 3); g++) begin
                    idle_junk();
                    if (parity_valid_o) early = 1'b1;
                end
            end
            drive(1'b1, 1'b1, 1'b0, mem[i]);
            if (i < 255 && parity_valid_o) early = 1'b1;
        end
        check({req, " R5 no early pulse"}, 32'(early), 32'd0);
        check({req, " R5 pulse"}, 32'(parity_valid_o), 32'd1);
        check({req, " R2 R3 raw parity"}, 32'(parity_o), 32'(exp_raw));
        check({req, " R9 R10 spare bytes"}, 32'(spare_o), 32'(model_spare(exp_raw)));
        drive(1'b0, 1'b0, 1'b0, 8'h00);
        check({req, " R5 pulse one cycle"}, 32'(parity_valid_o), 32'd0);
    endtask

    task automatic fill_random();
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    endtask

    initial begin
        logic [21:0] held;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(parity_valid_o), 32'd0);
        check("R1 reset parity", 32'(parity_o), 32'd0);
        check("R1 reset spare", 32'(spare_o), 32'hFFFFFF);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        run_chunk("zero chunk", 1'b0);

        fill_random();
        run_chunk("random chunk", 1'b0);

        fill_random();
        run_chunk("R4 gapped chunk", 1'b1);

        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[8'hA5] = 8'h08;
        run_chunk("single bit", 1'b0);
        check("R2 single bit column", 32'(parity_o[5:0]), 32'h1A);
        check("R10 offset0", 32'(spare_o[7:0]),   32'(~{parity_o, 2'b00} >> 16) & 32'hFF);
        check("R10 offset2", 32'(spare_o[23:16]), 32'(~{parity_o, 2'b00}) & 32'hFF);

        held = parity_o;
        for (int i = 0; i < 100; i++) drive(1'b1, 1'b1, 1'b0, 8'($urandom));
        drive(1'b0, 1'b0, 1'b1, 8'h00);
        check("R7 clear keeps result", 32'(parity_o), 32'(held));
        fill_random();
        run_chunk("R7 after clear", 1'b0);

        for (int i = 0; i < 40; i++) drive(1'b1, 1'b1, 1'b0, 8'($urandom));
        drive(1'b1, 1'b1, 1'b1, 8'hFF);
        fill_random();
        run_chunk("R7 clear with byte", 1'b0);

        fill_random();
        for (int i = 0; i < 256; i++) drive(1'b1, 1'b1, 1'b0, mem[i]);
        check("R6 first of pair", 32'(parity_o), 32'(model_raw()));
        fill_random();
        run_chunk("R6 back to back", 1'b0);

        held = parity_o;
        for (int i = 0; i < 20; i++) idle_junk();
        check("R8 hold parity", 32'(parity_o), 32'(held));
        check("R8 hold spare", 32'(spare_o), 32'(model_spare(held)));
        check("R4 no pulse on junk", 32'(parity_valid_o), 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule